// File: doc/BRIEF.md
# Register Shift Rotate Unit

This block is the shift and rotate datapath of a small RISC core. It takes a source operand, a shift-amount operand, the current T flag and a 4-bit operation code. In the same cycle it returns the shifted or rotated result and the value T should take next. It has no clock and no state. The core's decode stage drives the operation code, and the core's write-back logic decides when the outputs are captured.

The unit supports several groups of operations:

- single-place shifts that move the bit shifted out into T;
- plain rotates and rotates through T;
- fixed logical shifts by 2, 8 and 16 places;
- two dynamic shifts (arithmetic and logical) that are steered by a signed amount register. A negative amount selects a right shift, and the magnitude of that right shift is taken from a complemented 5-bit field.

Top module: `shrot_unit`

## Requirements
- R1: Code 0x1 (shift left one) returns the source shifted left by one with bit 0 cleared, and T becomes the old bit 31.
- R2: Code 0x2 (logical right one) clears bit 31 and code 0x3 (arithmetic right one) copies the old bit 31 into bit 31. Both shift right by one place, and for both T becomes the old bit 0.
- R3: Code 0x4 (rotate left) puts the old bit 31 into bit 0 and into T. Code 0x5 (rotate right) puts the old bit 0 into bit 31 and into T.
- R4: Code 0x6 (rotate left through T) fills bit 0 with the incoming T, and T becomes the old bit 31. Code 0x7 (rotate right through T) fills bit 31 with the incoming T, and T becomes the old bit 0.
- R5: The fixed shifts insert zeros and return T unchanged. The codes are 0x8, 0x9 and 0xA for left by 2, 8 and 16 places, and 0xB, 0xC and 0xD for right by 2, 8 and 16 places.
- R6: For the dynamic shifts (code 0xE arithmetic, code 0xF logical), an amount with bit 31 clear shifts left by amount[4:0] and fills with zeros. Amount bits 30 to 5 have no effect.
- R7: For the dynamic shifts, an amount with bit 31 set and amount[4:0] not zero shifts right by (~amount[4:0])+1 places. Code 0xE fills with the sign bit and code 0xF fills with zeros.
- R8: For the dynamic shifts, an amount with bit 31 set and amount[4:0] equal to zero has two outcomes. Code 0xE returns 32 copies of the source sign bit. Code 0xF returns zero.
- R9: Both dynamic shifts (codes 0xE and 0xF) return T unchanged.
- R10: Code 0x0 is undefined. It returns the source unchanged and keeps T.
- R11: The outputs depend only on the present inputs and settle within the same cycle. The unit holds no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | 32 | Operand to shift or rotate |
| amt_i | input | 32 | Signed amount for the dynamic shifts |
| t_i | input | 1 | Current T flag |
| op_i | input | 4 | Operation code |
| res_o | output | 32 | Result |
| t_o | output | 1 | Next T flag |

## Verification
The embedded checks are immediate and evaluated in combinational blocks. They assume that all four inputs are known values and that they change together, so that each check sees one settled operand set rather than a partial update. The stimulus meets this assumption. It drives every input at once on the falling edge of the bench clock and samples the outputs two nanoseconds later. It walks all sixteen codes, including the undefined one, with random operands and with the amount corners 0, 31, -1, -32 and 0x80000000.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  typedef enum logic [3:0] {
    OPC_NONE  = 4'h0,
    OPC_SL1   = 4'h1,
    OPC_SR1   = 4'h2,
    OPC_SA1   = 4'h3,
    OPC_ROTL  = 4'h4,
    OPC_ROTR  = 4'h5,
    OPC_RTL   = 4'h6,
    OPC_RTR   = 4'h7,
    OPC_SL2   = 4'h8,
    OPC_SL8   = 4'h9,
    OPC_SL16  = 4'hA,
    OPC_SR2   = 4'hB,
    OPC_SR8   = 4'hC,
    OPC_SR16  = 4'hD,
    OPC_DYNA  = 4'hE,
    OPC_DYNL  = 4'hF
  } shrot_op_e;
endpackage

// File: rtl/shrot_barrel.sv
module shrot_barrel #(
  parameter int WIDTH   = 32,
  parameter int STAGES  = 5,
  parameter bit TO_LEFT = 1'b1
) (
  input  logic [WIDTH-1:0]  data_i,
  input  logic [STAGES-1:0] cnt_i,
  input  logic              fill_i,
  output logic [WIDTH-1:0]  data_o
);
  logic [WIDTH-1:0] lvl [STAGES+1];
  assign lvl[0] = data_i;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam int SH = 1 << k;
    if (SH >= WIDTH) begin : g_full
      assign lvl[k+1] = cnt_i[k] ? {WIDTH{fill_i}} : lvl[k];
    end else if (TO_LEFT) begin : g_left
      assign lvl[k+1] = cnt_i[k] ? {lvl[k][WIDTH-1-SH:0], {SH{fill_i}}} : lvl[k];
    end else begin : g_right
      assign lvl[k+1] = cnt_i[k] ? {{SH{fill_i}}, lvl[k][WIDTH-1:SH]} : lvl[k];
    end
  end

  assign data_o = lvl[STAGES];
endmodule

// File: rtl/shrot_dyn.sv
module shrot_dyn #(
  parameter int WIDTH = 32,
  localparam int AB   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] src_i,
  input  logic             neg_i,
  input  logic [AB-1:0]    mag_i,
  input  logic             arith_i,
  output logic [WIDTH-1:0] res_o
);
  logic [WIDTH-1:0] left_res, right_res;
  logic [AB:0]      rcnt;
  logic             fill;

  // right count = (~mag)+1, reaching WIDTH when mag is zero
  assign rcnt = {1'b0, ~mag_i} + {{AB{1'b0}}, 1'b1};
  assign fill = arith_i & src_i[WIDTH-1];

  shrot_barrel #(.WIDTH(WIDTH), .STAGES(AB), .TO_LEFT(1'b1)) u_left (
    .data_i(src_i), .cnt_i(mag_i), .fill_i(1'b0), .data_o(left_res)
  );

  shrot_barrel #(.WIDTH(WIDTH), .STAGES(AB+1), .TO_LEFT(1'b0)) u_right (
    .data_i(src_i), .cnt_i(rcnt), .fill_i(fill), .data_o(right_res)
  );

  assign res_o = neg_i ? right_res : left_res;

  always_comb begin
    if (neg_i && mag_i == '0) begin
      // R8
      dyn_zero_field_chk: assert (res_o == {WIDTH{fill}})
        else $error("dynamic shift with zero field did not fill");
    end
    if (!neg_i && mag_i == '0) begin
      // R6
      dyn_zero_left_chk: assert (res_o == src_i)
        else $error("left shift by zero changed the source");
    end
  end
endmodule

// File: rtl/shrot_fixed.sv
module shrot_fixed
  import shrot_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] src_i,
  input  logic             t_i,
  input  shrot_op_e        op_i,
  output logic [WIDTH-1:0] res_o,
  output logic             t_o
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    res_o = src_i;
    t_o   = t_i;
    case (op_i)
      OPC_SL1:  begin res_o = {src_i[MSB-1:0], 1'b0};       t_o = src_i[MSB]; end
      OPC_SR1:  begin res_o = {1'b0, src_i[MSB:1]};         t_o = src_i[0];   end
      OPC_SA1:  begin res_o = {src_i[MSB], src_i[MSB:1]};   t_o = src_i[0];   end
      OPC_ROTL: begin res_o = {src_i[MSB-1:0], src_i[MSB]}; t_o = src_i[MSB]; end
      OPC_ROTR: begin res_o = {src_i[0], src_i[MSB:1]};     t_o = src_i[0];   end
      OPC_RTL:  begin res_o = {src_i[MSB-1:0], t_i};        t_o = src_i[MSB]; end
      OPC_RTR:  begin res_o = {t_i, src_i[MSB:1]};          t_o = src_i[0];   end
      OPC_SL2:  res_o = src_i << 2;
      OPC_SL8:  res_o = src_i << 8;
      OPC_SL16: res_o = src_i << 16;
      OPC_SR2:  res_o = src_i >> 2;
      OPC_SR8:  res_o = src_i >> 8;
      OPC_SR16: res_o = src_i >> 16;
      default:  ;
    endcase
  end

  always_comb begin
    if (op_i == OPC_ROTL || op_i == OPC_ROTR) begin
      // R3
      rot_ones_chk: assert ($countones(res_o) == $countones(src_i))
        else $error("plain rotate lost or gained a bit");
    end
    if (op_i == OPC_RTL || op_i == OPC_RTR) begin
      // R4
      rot_thru_ones_chk: assert ($countones({res_o, t_o}) == $countones({src_i, t_i}))
        else $error("rotate through T lost or gained a bit");
    end
    if (op_i >= OPC_SL2 && op_i <= OPC_SR16) begin
      // R5
      fixed_keep_t_chk: assert (t_o == t_i)
        else $error("fixed shift altered T");
    end
  end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] src_i,
  input  logic [WIDTH-1:0] amt_i,
  input  logic             t_i,
  input  logic [3:0]       op_i,
  output logic [WIDTH-1:0] res_o,
  output logic             t_o
);
  localparam int AB = $clog2(WIDTH);

  shrot_op_e        op;
  logic [WIDTH-1:0] fix_res, dyn_res;
  logic             fix_t;
  logic             is_dyn;
  logic             unused_amt_bits;

  assign op              = shrot_op_e'(op_i);
  assign is_dyn          = (op == OPC_DYNA) || (op == OPC_DYNL);
  assign unused_amt_bits = ^amt_i[WIDTH-2:AB];

  shrot_fixed #(.WIDTH(WIDTH)) u_fixed (
    .src_i(src_i), .t_i(t_i), .op_i(op), .res_o(fix_res), .t_o(fix_t)
  );

  shrot_dyn #(.WIDTH(WIDTH)) u_dyn (
    .src_i(src_i), .neg_i(amt_i[WIDTH-1]), .mag_i(amt_i[AB-1:0]),
    .arith_i(op == OPC_DYNA), .res_o(dyn_res)
  );

  always_comb begin
    if (is_dyn) begin
      res_o = dyn_res;
      t_o   = t_i;
    end else begin
      res_o = fix_res;
      t_o   = fix_t;
    end
  end

  always_comb begin
    if (op == OPC_NONE) begin
      // R10
      undef_pass_chk: assert (res_o == src_i && t_o == t_i)
        else $error("undefined code altered the outputs");
    end
    if (is_dyn) begin
      // R9
      dyn_keep_t_chk: assert (t_o == t_i)
        else $error("dynamic shift altered T");
    end
  end
endmodule

// File: tb/shrot_unit_test.sv
module shrot_unit_test;
  logic        clk = 1'b0;
  logic [31:0] src, amt, res;
  logic        tin, tout;
  logic [3:0]  op;
  int          checks = 0, failures = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  shrot_unit uut (.src_i(src), .amt_i(amt), .t_i(tin), .op_i(op), .res_o(res), .t_o(tout));

  // {req, op, src, amt, t, expected result, expected t}
  localparam int NV = 25;
  localparam logic [105:0] VEC [NV] = '{
    {4'd1,  4'h1, 32'h80000001, 32'h0, 1'b0, 32'h00000002, 1'b1}, // R1
    {4'd2,  4'h2, 32'h80000001, 32'h0, 1'b0, 32'h40000000, 1'b1}, // R2
    {4'd2,  4'h3, 32'h80000002, 32'h0, 1'b1, 32'hC0000001, 1'b0}, // R2
    {4'd3,  4'h4, 32'h80000000, 32'h0, 1'b0, 32'h00000001, 1'b1}, // R3
    {4'd3,  4'h5, 32'h00000001, 32'h0, 1'b0, 32'h80000000, 1'b1}, // R3
    {4'd4,  4'h6, 32'h80000000, 32'h0, 1'b0, 32'h00000000, 1'b1}, // R4
    {4'd4,  4'h6, 32'h00000001, 32'h0, 1'b1, 32'h00000003, 1'b0}, // R4
    {4'd4,  4'h7, 32'h00000001, 32'h0, 1'b0, 32'h00000000, 1'b1}, // R4
    {4'd4,  4'h7, 32'h00000002, 32'h0, 1'b1, 32'h80000001, 1'b0}, // R4
    {4'd5,  4'h8, 32'hC0000001, 32'h0, 1'b1, 32'h00000004, 1'b1}, // R5
    {4'd5,  4'h9, 32'h12345678, 32'h0, 1'b0, 32'h34567800, 1'b0}, // R5
    {4'd5,  4'hA, 32'h12345678, 32'h0, 1'b1, 32'h56780000, 1'b1}, // R5
    {4'd5,  4'hB, 32'h80000003, 32'h0, 1'b0, 32'h20000000, 1'b0}, // R5
    {4'd5,  4'hC, 32'h12345678, 32'h0, 1'b1, 32'h00123456, 1'b1}, // R5
    {4'd5,  4'hD, 32'h12345678, 32'h0, 1'b0, 32'h00001234, 1'b0}, // R5
    {4'd6,  4'hE, 32'h0000000F, 32'h00000004, 1'b0, 32'h000000F0, 1'b0}, // R6
    {4'd6,  4'hE, 32'h00000001, 32'h7FFFFFE3, 1'b1, 32'h00000008, 1'b1}, // R6
    {4'd6,  4'hF, 32'h00000001, 32'h0000001F, 1'b0, 32'h80000000, 1'b0}, // R6
    {4'd7,  4'hE, 32'h80000000, 32'hFFFFFFFF, 1'b0, 32'hC0000000, 1'b0}, // R7
    {4'd7,  4'hF, 32'h80000000, 32'hFFFFFFFF, 1'b1, 32'h40000000, 1'b1}, // R7
    {4'd8,  4'hE, 32'h80000000, 32'h80000000, 1'b0, 32'hFFFFFFFF, 1'b0}, // R8
    {4'd8,  4'hE, 32'h7FFFFFFF, 32'hFFFFFFE0, 1'b1, 32'h00000000, 1'b1}, // R8
    {4'd8,  4'hF, 32'hFFFFFFFF, 32'hFFFFFFE0, 1'b0, 32'h00000000, 1'b0}, // R8
    {4'd9,  4'hF, 32'h12345678, 32'h00000000, 1'b1, 32'h12345678, 1'b1}, // R9
    {4'd10, 4'h0, 32'hDEADBEEF, 32'h00000005, 1'b1, 32'hDEADBEEF, 1'b1}  // R10
  };

  function automatic logic [32:0] ref_model(logic [3:0] o, logic [31:0] s, logic [31:0] a, logic t);
    logic [31:0] r = s;
    logic        nt = t;
    int          n;
    case (o)
      4'h1: begin r = s * 2; nt = s[31]; end
      4'h2: begin r = s / 2; nt = s[0]; end
      4'h3: begin r = 32'($signed(s) >>> 1); nt = s[0]; end
      4'h4: begin r = (s << 1) | (s >> 31); nt = s[31]; end
      4'h5: begin r = (s >> 1) | (s << 31); nt = s[0]; end
      4'h6: begin r = (s << 1) | {31'b0, t}; nt = s[31]; end
      4'h7: begin r = (s >> 1) | {t, 31'b0}; nt = s[0]; end
      4'h8: r = s * 4;
      4'h9: r = s * 256;
      4'hA: r = s * 65536;
      4'hB: r = s / 4;
      4'hC: r = s / 256;
      4'hD: r = s / 65536;
      4'hE, 4'hF: begin
        if (!a[31]) r = s << a[4:0];
        else begin
          n = 32 - int'(a[4:0]);
          if (n == 32) r = (o == 4'hE && s[31]) ? 32'hFFFFFFFF : 32'h0;
          else if (o == 4'hE) r = 32'($signed(s) >>> n);
          else r = s >> n;
        end
      end
      default: ;
    endcase
    return {nt, r};
  endfunction

  function automatic int req_of(logic [3:0] o, logic [31:0] a);
    if (o == 4'h0) return 10;
    if (o == 4'h1) return 1;
    if (o <= 4'h3) return 2;
    if (o <= 4'h5) return 3;
    if (o <= 4'h7) return 4;
    if (o <= 4'hD) return 5;
    if (!a[31]) return 6;
    if (a[4:0] != 0) return 7;
    return 8;
  endfunction

  task automatic run_one(logic [3:0] o, logic [31:0] s, logic [31:0] a, logic t,
                         logic [31:0] er, logic et, int rq);
    @(negedge clk);
    op = o; src = s; amt = a; tin = t;
    #2;
    checks++;
    if (res !== er || tout !== et) begin
      failures++;
      $display("FAIL R%0d op=%h src=%h amt=%h: actual res=%h t=%b expected res=%h t=%b",
               rq, o, s, a, res, tout, er, et);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [32:0] exp;
    logic [31:0] corner [5];
    op = 4'h0; src = '0; amt = '0; tin = 1'b0;
    corner[0] = 32'h0; corner[1] = 32'd31; corner[2] = 32'hFFFFFFFF;
    corner[3] = 32'hFFFFFFE0; corner[4] = 32'h80000000;

    // R11: outputs follow the inputs in the same cycle, no history kept
    run_one(4'h0, 32'h0, 32'h0, 1'b0, 32'h0, 1'b0, 11);

    for (int i = 0; i < NV; i++) begin
      run_one(VEC[i][101:98], VEC[i][97:66], VEC[i][65:34], VEC[i][33],
              VEC[i][32:1], VEC[i][0], int'(VEC[i][105:102]));
    end

    // R6 R7 R8: amount corners on every code
    for (int o = 0; o < 16; o++) begin
      for (int c = 0; c < 5; c++) begin
        logic [31:0] s = $urandom;
        logic        t = 1'($urandom);
        exp = ref_model(4'(o), s, corner[c], t);
        run_one(4'(o), s, corner[c], t, exp[31:0], exp[32], req_of(4'(o), corner[c]));
      end
    end

    // R1 to R10 with random operands
    for (int o = 0; o < 16; o++) begin
      for (int k = 0; k < 60; k++) begin
        logic [31:0] s = $urandom;
        logic [31:0] a = $urandom;
        logic        t = 1'($urandom);
        exp = ref_model(4'(o), s, a, t);
        run_one(4'(o), s, a, t, exp[31:0], exp[32], req_of(4'(o), a));
      end
    end

    // R11: same operands after other traffic give the same answer
    run_one(4'h6, 32'h00000001, 32'h0, 1'b1, 32'h00000003, 1'b0, 11);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule